// File: doc/BRIEF.md
# Bit-Field and Byte-Shuffle Unit

This combinational datapath block serves the bit-manipulation group of a 32-bit integer pipeline. Given the function code of an already-recognised bit-manipulation instruction, its 5-bit position field, its 5-bit size field and the two source operands, it produces the value to be written back. It also raises a flag when the encoding names no supported operation.

Two operations work on a bit field whose width is the size field plus one. Extract pulls a field out of the first operand and right-aligns it. Insert places the low bits of the first operand into the second operand and keeps every other bit of the second operand.

A third function code opens a small group of byte operations that read only the second operand. The position field acts as a sub-selector within that group. The group covers a byte swap inside each 16-bit half, sign extension of the low byte, and sign extension of the low halfword.

Top module: `bitfield_unit`

## Requirements
- R1: With function code 0 (extract) the result is (rs >> pos) masked to its low size+1 bits; all higher result bits are zero.
- R2: A size field of 31 gives a field mask of all ones, so extract with pos 0 and size 31 returns rs unchanged.
- R3: With function code 4 (insert) the result is ((rs & mask) << pos) | (rt & ~(mask << pos)), where mask holds size+1 ones, truncated to 32 bits.
- R4: Insert keeps every bit of rt outside the field pos .. pos+size; with pos 31 and size 0 only bit 31 changes.
- R5: With function code 32 and sub-selector (pos field) 2 the result swaps the two bytes of each 16-bit half of rt.
- R6: With function code 32 and sub-selector 16 the result is rt bits 7:0 sign-extended to 32 bits.
- R7: With function code 32 and sub-selector 24 the result is rt bits 15:0 sign-extended to 32 bits.
- R8: The byte-group operations ignore rs and the size field; changing them leaves the result the same.
- R9: Any function code other than 0, 4 and 32 raises the illegal flag and forces the result to zero.
- R10: With function code 32, any sub-selector other than 2, 16 and 24 raises the illegal flag and forces the result to zero.
- R11: Every supported encoding leaves the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_i | input | 6 | Function code: 0 extract, 4 insert, 32 byte group |
| pos_i | input | 5 | Field position (LSB); sub-selector in the byte group |
| size_i | input | 5 | Field width minus one |
| rs_i | input | 32 | First source operand |
| rt_i | input | 32 | Second source operand |
| result_o | output | 32 | Operation result, zero when illegal |
| illegal_o | output | 1 | High when the encoding is unsupported |

## Verification
Every result is due in the same cycle as its inputs, since no register lies on any path. The driver applies a stimulus on the falling clock edge and queues the expected value. The monitor pops and compares on the next rising edge, half a period later, so each comparison reads settled logic and exactly one item is in flight. The reference model builds its mask with 64-bit arithmetic, so a size of 31 needs no special case there.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DW  = 32,
  parameter int FNW = 6,
  parameter int FLW = 5
) (
  input  logic [FNW-1:0] func_i,
  input  logic [FLW-1:0] pos_i,
  input  logic [FLW-1:0] size_i,
  input  logic [DW-1:0]  rs_i,
  input  logic [DW-1:0]  rt_i,
  output logic [DW-1:0]  result_o,
  output logic           illegal_o
);
  localparam int HALVES = DW / 16;
  localparam logic [FNW-1:0] FN_EXT  = FNW'(0);
  localparam logic [FNW-1:0] FN_INS  = FNW'(4);
  localparam logic [FNW-1:0] FN_BYTE = FNW'(32);
  localparam logic [FLW-1:0] SUB_SWAP = FLW'(2);
  localparam logic [FLW-1:0] SUB_SXB  = FLW'(16);
  localparam logic [FLW-1:0] SUB_SXH  = FLW'(24);

  logic [DW-1:0] fmask, ext_r, ins_r, swap_r, sxb_r, sxh_r;

  always_comb begin
    for (int i = 0; i < DW; i++)
      fmask[i] = (i <= int'(size_i));
  end

  assign ext_r = (rs_i >> pos_i) & fmask;
  assign ins_r = ((rs_i & fmask) << pos_i) | (rt_i & ~(fmask << pos_i));
  assign sxb_r = {{(DW-8){rt_i[7]}}, rt_i[7:0]};
  assign sxh_r = {{(DW-16){rt_i[15]}}, rt_i[15:0]};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign swap_r[h*16 +: 8]   = rt_i[h*16+8 +: 8];
    assign swap_r[h*16+8 +: 8] = rt_i[h*16 +: 8];
  end

  always_comb begin
    result_o  = '0;
    illegal_o = 1'b0;
    unique case (func_i)
      FN_EXT: result_o = ext_r;
      FN_INS: result_o = ins_r;
      FN_BYTE: begin
        unique case (pos_i)
          SUB_SWAP: result_o = swap_r;
          SUB_SXB:  result_o = sxb_r;
          SUB_SXH:  result_o = sxh_r;
          default:  illegal_o = 1'b1;
        endcase
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
  input logic [5:0]  func_i,
  input logic [4:0]  pos_i,
  input logic [4:0]  size_i,
  input logic [31:0] rs_i,
  input logic [31:0] rt_i,
  input logic [31:0] result_o,
  input logic        illegal_o
);
  logic [31:0] below_pos;
  assign below_pos = (32'd1 << pos_i) - 32'd1;

  always_comb begin
    if (illegal_o)
      assert_illegal_zero_R9: assert (result_o == 32'd0);
    if (func_i == 6'd0 || func_i == 6'd4)
      assert_field_legal_R11: assert (!illegal_o);
    if (func_i == 6'd0)
      assert_ext_high_clear_R1: assert (((result_o >> size_i) >> 1) == 32'd0);
    if (func_i == 6'd4)
      assert_ins_keep_low_R4: assert (((result_o ^ rt_i) & below_pos) == 32'd0);
    if (func_i == 6'd32 && pos_i == 5'd2)
      assert_swap_bytes_R5: assert (result_o[7:0] == rt_i[15:8] && result_o[31:24] == rt_i[23:16]);
    if (func_i == 6'd32 && pos_i == 5'd16)
      assert_sxb_fill_R6: assert (result_o[7:0] == rt_i[7:0] && (result_o[31:8] == '0 || result_o[31:8] == '1) && result_o[8] == result_o[7]);
    if (func_i == 6'd32 && pos_i == 5'd24)
      assert_sxh_fill_R7: assert (result_o[15:0] == rt_i[15:0] && (result_o[31:16] == '0 || result_o[31:16] == '1) && result_o[16] == result_o[15]);
    if (func_i == 6'd32 && pos_i != 5'd2 && pos_i != 5'd16 && pos_i != 5'd24)
      assert_bad_sub_R10: assert (illegal_o);
  end
endmodule

bind bitfield_unit bitfield_unit_chk chk_i (
  .func_i(func_i), .pos_i(pos_i), .size_i(size_i), .rs_i(rs_i), .rt_i(rt_i),
  .result_o(result_o), .illegal_o(illegal_o)
);

// File: tb/bitfield_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [5:0]  func_i = '0;
  logic [4:0]  pos_i = '0;
  logic [4:0]  size_i = '0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic [31:0] result_o;
  logic        illegal_o;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitfield_unit dut_i (
    .func_i(func_i), .pos_i(pos_i), .size_i(size_i), .rs_i(rs_i), .rt_i(rt_i),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic exp_t model(logic [5:0] f, logic [4:0] p, logic [4:0] s,
                                 logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    logic [63:0] m, r;
    m = (64'd1 << (s + 1)) - 64'd1;
    e.tag = tag; e.ill = 1'b0; e.res = '0;
    case (f)
      6'd0: begin r = ({32'd0, a} >> p) & m; e.res = r[31:0]; end
      6'd4: begin r = (({32'd0, a} & m) << p) | ({32'd0, b} & ~(m << p)); e.res = r[31:0]; end
      6'd32: case (p)
        5'd2:  e.res = {b[23:16], b[31:24], b[7:0], b[15:8]};
        5'd16: e.res = 32'(signed'(b[7:0]));
        5'd24: e.res = 32'(signed'(b[15:0]));
        default: e.ill = 1'b1;
      endcase
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  task automatic drive(logic [5:0] f, logic [4:0] p, logic [4:0] s,
                       logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk);
    func_i = f; pos_i = p; size_i = s; rs_i = a; rt_i = b;
    q.push_back(model(f, p, s, a, b, tag));
  endtask

  task automatic expect_raw(logic [31:0] r, logic il, string tag);
    exp_t e;
    @(negedge clk);
    e.res = r; e.ill = il; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result_o !== e.res || illegal_o !== e.ill) begin
        errors++;
        $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                 e.tag, result_o, illegal_o, e.res, e.ill);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    expect_raw(32'd0, 1'b0, "R11 idle");
    drive(6'd0, 5'd4, 5'd7, 32'hDEADBEEF, 32'h0, "R1 ext mid");
    expect_raw(32'h000000EE, 1'b0, "R1 ext literal");
    drive(6'd0, 5'd0, 5'd31, 32'hCAFEF00D, 32'h0, "R2 ext full");
    expect_raw(32'hCAFEF00D, 1'b0, "R2 ext full literal");
    drive(6'd0, 5'd31, 5'd0, 32'h80000000, 32'h0, "R1 ext top bit");
    drive(6'd4, 5'd8, 5'd7, 32'h000000AB, 32'h11223344, "R3 ins byte");
    expect_raw(32'h1122AB44, 1'b0, "R3 ins literal");
    drive(6'd4, 5'd0, 5'd31, 32'h12345678, 32'hFFFFFFFF, "R2 ins full");
    drive(6'd4, 5'd31, 5'd0, 32'hFFFFFFFF, 32'h00000000, "R4 ins top");
    expect_raw(32'h80000000, 1'b0, "R4 ins top literal");
    drive(6'd4, 5'd31, 5'd0, 32'h00000000, 32'h7FFFFFFF, "R4 ins keep");
    drive(6'd32, 5'd2, 5'd0, 32'h0, 32'h11223344, "R5 swap");
    expect_raw(32'h22114433, 1'b0, "R5 swap literal");
    drive(6'd32, 5'd16, 5'd0, 32'h0, 32'h00000080, "R6 sxb neg");
    expect_raw(32'hFFFFFF80, 1'b0, "R6 sxb literal");
    drive(6'd32, 5'd16, 5'd0, 32'h0, 32'hFFFFFF7F, "R6 sxb pos");
    drive(6'd32, 5'd24, 5'd0, 32'h0, 32'h00018000, "R7 sxh neg");
    expect_raw(32'hFFFF8000, 1'b0, "R7 sxh literal");
    drive(6'd32, 5'd24, 5'd9, 32'hFFFFFFFF, 32'h12347FFF, "R8 sxh ignores rs/size");
    expect_raw(32'h00007FFF, 1'b0, "R8 sxh literal");
    drive(6'd32, 5'd2, 5'd31, 32'h55555555, 32'h11223344, "R8 swap ignores rs/size");
    expect_raw(32'h22114433, 1'b0, "R8 swap literal");
    drive(6'd1, 5'd3, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, "R9 bad func");
    expect_raw(32'd0, 1'b1, "R9 literal");
    drive(6'd63, 5'd0, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R9 bad func 63");
    drive(6'd32, 5'd0, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10 bad sub 0");
    drive(6'd32, 5'd31, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10 bad sub 31");
    expect_raw(32'd0, 1'b1, "R10 literal");
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f;
      logic [4:0] p;
      string t;
      case (i % 5)
        0: begin f = 6'd0; t = "R1 random ext"; end
        1: begin f = 6'd4; t = "R3 random ins"; end
        2: begin f = 6'd32; t = "R5 R6 R7 random byte group"; end
        3: begin f = 6'(32 + ($urandom % 2) * 0); t = "R10 random byte group"; end
        default: begin f = 6'($urandom); t = "R9 random func"; end
      endcase
      p = 5'($urandom);
      if (i % 5 == 2) p = (i % 3 == 0) ? 5'd2 : ((i % 3 == 1) ? 5'd16 : 5'd24);
      drive(f, p, 5'($urandom), $urandom, $urandom, t);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule